// File: doc/BRIEF.md
# JPEG Header Marker Parser

This block sits at the front of a baseline JPEG decoder. It takes the compressed file as 32-bit words over a valid/read handshake and splits each word into bytes, lowest byte first. It then finds the 0xFF-prefixed markers and walks the header segments that follow. Quantization-table and Huffman-table contents leave on two simple write ports, one entry per cycle. The frame header supplies the image height and width and is checked for the one chroma layout the decoder supports.

After the scan header, the block forwards entropy-coded bytes with byte stuffing removed. It does this until the end-of-image marker, then pulses done and returns to idle. Application segments are skipped by their length. Any other marker stops the decode with a sticky error flag, including the restart-interval definition, the restart codes and the comment marker.

A host pulses start while idle is high. It then offers words, and holds each one until the read strobe takes it.

Top module: `jpg_hdr_walker`

## Requirements
- R1: After reset, idle_o is 1 and in_rd_o, done_o and err_o are 0. While idle, in_vld_i is ignored (in_rd_o stays 0). A one-cycle start_i pulse while idle begins a decode and drops idle_o.
- R2: Bytes within a word are taken in little-endian order: bits 7:0 first, bits 31:24 last. Each accepted word produces exactly one cycle of in_rd_o.
- R3: The stream must open with 0xFF 0xD8; any other first two bytes set err_o and return to idle.
- R4: A quantization segment (code 0xDB) holds one or more tables. Each table starts with a byte whose upper nibble is the precision (must be 0, else error) and whose bits 1:0 give the table id. The table's 64 value bytes are each written as (id, index 0..63, value) with qt_we_o high for one cycle.
- R5: A Huffman segment (code 0xC4) holds one or more tables. Each starts with a byte whose bit 4 is the class and bits 1:0 the id. Next come 16 count bytes, written at indices 0..15, then as many symbol bytes as the counts add up to, written at indices 16 upward, each with ht_we_o for one cycle.
- R6: The baseline frame header (code 0xC0) supplies height from body bytes 1..2 and width from body bytes 3..4, both big-endian. img_h_o and img_w_o show them and stay unchanged until the next start, which clears them to 0.
- R7: The frame header must declare 3 components with sampling bytes 0x22, 0x11, 0x11 (body bytes 7, 10, 13) and a 15-byte body; otherwise err_o is set.
- R8: Application segments (codes 0xE0..0xEF) are skipped by their 16-bit big-endian length (which counts its own two bytes). Their contents cause no table write and no error.
- R9: The restart-interval marker 0xDD in the header, and a restart code 0xD0..0xD7 after 0xFF in entropy data, set err_o and return the block to idle.
- R10: After the scan header (code 0xDA, body skipped), each entropy byte goes out on ecs_byte_o with ecs_vld_o. The pair 0xFF 0x00 gives a single 0xFF. Extra 0xFF fill bytes before a marker code are dropped.
- R11: 0xFF 0xD9 ends the image: done_o is high for one cycle, idle_o returns to 1, and no further word is read, even when the end code sits in the last byte of a word while another word is offered.
- R12: err_o stays set until the next start. Any marker code outside the supported set (for example 0xFE) also sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a decode |
| idle_o | output | 1 | High when no decode is in progress |
| done_o | output | 1 | One-cycle pulse at end of image |
| err_o | output | 1 | Sticky error flag, cleared by start |
| in_word_i | input | 32 | Input word, lowest byte first |
| in_vld_i | input | 1 | Input word is valid |
| in_rd_o | output | 1 | Input word taken this cycle |
| qt_we_o | output | 1 | Quantization-table write strobe |
| qt_id_o | output | 2 | Quantization table id |
| qt_idx_o | output | 6 | Quantization entry index |
| qt_val_o | output | 8 | Quantization entry value |
| ht_we_o | output | 1 | Huffman-table write strobe |
| ht_class_o | output | 1 | Huffman table class |
| ht_id_o | output | 2 | Huffman table id |
| ht_idx_o | output | 9 | 0..15 counts, 16 and up symbols |
| ht_val_o | output | 8 | Count or symbol value |
| img_w_o | output | 16 | Image width |
| img_h_o | output | 16 | Image height |
| ecs_vld_o | output | 1 | Entropy byte valid |
| ecs_byte_o | output | 8 | Unstuffed entropy byte |

## Verification
The end-of-image code and the fetch of the next input word can land in the same cycle. This happens when 0xD9 is the last byte of a word while the host already offers the following word. The bench pads the entropy data with 0xFF fill so that the end code falls in the top byte lane. It then keeps a further word valid after the image. The outcome is judged by counting read strobes against the words the image occupies, and by checking that no strobe appears while the extra word waits.

// File: rtl/jhw_pkg.sv
package jhw_pkg;
  localparam logic [7:0] MK_PFX  = 8'hFF;
  localparam logic [7:0] MK_SOI  = 8'hD8;
  localparam logic [7:0] MK_EOI  = 8'hD9;
  localparam logic [7:0] MK_DQT  = 8'hDB;
  localparam logic [7:0] MK_DHT  = 8'hC4;
  localparam logic [7:0] MK_SOF0 = 8'hC0;
  localparam logic [7:0] MK_SOS  = 8'hDA;
  localparam logic [7:0] SAMP_Y  = 8'h22;
  localparam logic [7:0] SAMP_C  = 8'h11;

  typedef enum logic [4:0] {
    P_IDLE, P_SOI0, P_SOI1, P_MFF, P_MCODE, P_LENH, P_LENL,
    P_SKIP, P_QHDR, P_QVAL, P_HHDR, P_HCNT, P_HSYM,
    P_FRM, P_SCAN, P_ECS, P_ECSFF
  } pstate_t;

  typedef enum logic [2:0] {K_APP, K_DQT, K_DHT, K_SOF, K_SOS} seg_t;
endpackage

// File: rtl/jhw_unpack.sv
module jhw_unpack #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          stop_i,
  input  logic [DW-1:0] word_i,
  input  logic          vld_i,
  output logic          rd_o,
  output logic          byte_vld_o,
  output logic [BW-1:0] byte_o
);
  localparam int LANES = DW / BW;
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IW-1:0] LAST = IW'(LANES - 1);

  logic          full_q, full_n;
  logic [DW-1:0] word_q, word_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          take;

  assign take = active_i & vld_i & ~stop_i & (~full_q | (idx_q == LAST));
  assign rd_o = take;
  assign byte_vld_o = full_q & active_i;
  assign byte_o = BW'(word_q >> (BW * int'(idx_q)));

  always_comb begin
    full_n = full_q;
    word_n = word_q;
    idx_n  = idx_q;
    if (stop_i || !active_i) begin
      full_n = 1'b0;
    end else if (take) begin
      word_n = word_i;
      idx_n  = '0;
      full_n = 1'b1;
    end else if (full_q) begin
      idx_n = idx_q + 1'b1;
      if (idx_q == LAST) full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      full_q <= full_n;
      word_q <= word_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/jhw_parse.sv
module jhw_parse
  import jhw_pkg::*;
#(
  parameter int BW  = 8,
  parameter int LW  = 16,
  parameter int XW  = 9,
  parameter int SW  = 12,
  parameter int QN  = 64,
  parameter int HC  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bvld_i,
  input  logic [BW-1:0] byte_i,
  output logic          idle_o,
  output logic          end_o,
  output logic          done_o,
  output logic          err_o,
  output logic          qt_we_o,
  output logic [1:0]    qt_id_o,
  output logic          ht_we_o,
  output logic          ht_cls_o,
  output logic [1:0]    ht_id_o,
  output logic [XW-1:0] idx_o,
  output logic [BW-1:0] val_o,
  output logic          ecs_vld_o,
  output logic [LW-1:0] w_o,
  output logic [LW-1:0] h_o
);
  localparam logic [XW-1:0] Q_END = XW'(QN - 1);
  localparam logic [XW-1:0] H_END = XW'(HC - 1);

  pstate_t       st, st_n;
  seg_t          kind, kind_n;
  logic [LW-1:0] rem, rem_n, w_q, w_n, h_q, h_n, seglen;
  logic [BW-1:0] lenh, lenh_n, val_n;
  logic [XW-1:0] cnt, cnt_n, idx_n;
  logic [SW-1:0] sum, sum_n;
  logic [1:0]    qid, qid_n, hid, hid_n;
  logic          hcls, hcls_n, errf, errf_n;
  logic          qwe_n, hwe_n, ewe_n, done_n, fail, finish, last;

  assign seglen = {lenh, byte_i};
  assign last   = (rem == LW'(1));

  always_comb begin
    st_n = st;     kind_n = kind;  rem_n = rem;   lenh_n = lenh;
    cnt_n = cnt;   sum_n = sum;    qid_n = qid;   hid_n = hid;
    hcls_n = hcls; w_n = w_q;      h_n = h_q;     errf_n = errf;
    qwe_n = 1'b0;  hwe_n = 1'b0;   ewe_n = 1'b0;  done_n = 1'b0;
    idx_n = cnt;   val_n = byte_i; fail = 1'b0;   finish = 1'b0;
    if (st == P_IDLE) begin
      if (start_i) begin
        st_n = P_SOI0; errf_n = 1'b0; w_n = '0; h_n = '0;
      end
    end else if (bvld_i) begin
      case (st)
        P_SOI0: if (byte_i == MK_PFX) st_n = P_SOI1; else fail = 1'b1;
        P_SOI1: if (byte_i == MK_SOI) st_n = P_MFF; else fail = 1'b1;
        P_MFF:  if (byte_i == MK_PFX) st_n = P_MCODE; else fail = 1'b1;
        P_MCODE: begin
          st_n = P_LENH;
          if (byte_i == MK_PFX)           st_n = P_MCODE;
          else if (byte_i == MK_EOI)      finish = 1'b1;
          else if (byte_i == MK_DQT)      kind_n = K_DQT;
          else if (byte_i == MK_DHT)      kind_n = K_DHT;
          else if (byte_i == MK_SOF0)     kind_n = K_SOF;
          else if (byte_i == MK_SOS)      kind_n = K_SOS;
          else if (byte_i[7:4] == 4'hE)   kind_n = K_APP;
          else                            fail = 1'b1;
        end
        P_LENH: begin lenh_n = byte_i; st_n = P_LENL; end
        P_LENL: begin
          rem_n = seglen - LW'(2);
          cnt_n = '0;
          if (seglen < LW'(2)) fail = 1'b1;
          else if (seglen == LW'(2)) begin
            if (kind == K_SOF) fail = 1'b1;
            st_n = (kind == K_SOS) ? P_ECS : P_MFF;
          end else begin
            case (kind)
              K_DQT:   st_n = P_QHDR;
              K_DHT:   st_n = P_HHDR;
              K_SOF:   st_n = P_FRM;
              K_SOS:   st_n = P_SCAN;
              default: st_n = P_SKIP;
            endcase
          end
        end
        P_SKIP: begin rem_n = rem - 1'b1; if (last) st_n = P_MFF; end
        P_QHDR: begin
          rem_n = rem - 1'b1; qid_n = byte_i[1:0]; cnt_n = '0;
          if (byte_i[7:4] != 4'h0) fail = 1'b1;
          st_n = last ? P_MFF : P_QVAL;
        end
        P_QVAL: begin
          rem_n = rem - 1'b1; qwe_n = 1'b1; cnt_n = cnt + 1'b1;
          if (last) st_n = P_MFF;
          else if (cnt == Q_END) st_n = P_QHDR;
        end
        P_HHDR: begin
          rem_n = rem - 1'b1; hcls_n = byte_i[4]; hid_n = byte_i[1:0];
          cnt_n = '0; sum_n = '0;
          st_n = last ? P_MFF : P_HCNT;
        end
        P_HCNT: begin
          rem_n = rem - 1'b1; hwe_n = 1'b1; cnt_n = cnt + 1'b1;
          sum_n = sum + SW'(byte_i);
          if (last) st_n = P_MFF;
          else if (cnt == H_END) st_n = (sum_n == '0) ? P_HHDR : P_HSYM;
        end
        P_HSYM: begin
          rem_n = rem - 1'b1; hwe_n = 1'b1; cnt_n = cnt + 1'b1;
          sum_n = sum - 1'b1;
          if (last) st_n = P_MFF;
          else if (sum == SW'(1)) st_n = P_HHDR;
        end
        P_FRM: begin
          rem_n = rem - 1'b1; cnt_n = cnt + 1'b1;
          case (cnt)
            XW'(1):  h_n[15:8] = byte_i;
            XW'(2):  h_n[7:0]  = byte_i;
            XW'(3):  w_n[15:8] = byte_i;
            XW'(4):  w_n[7:0]  = byte_i;
            XW'(5):  if (byte_i != 8'd3) fail = 1'b1;
            XW'(7):  if (byte_i != SAMP_Y) fail = 1'b1;
            XW'(10): if (byte_i != SAMP_C) fail = 1'b1;
            XW'(13): if (byte_i != SAMP_C) fail = 1'b1;
            default: ;
          endcase
          if (cnt > XW'(14)) fail = 1'b1;
          if (last) begin
            if (cnt != XW'(14)) fail = 1'b1;
            st_n = P_MFF;
          end
        end
        P_SCAN: begin rem_n = rem - 1'b1; if (last) st_n = P_ECS; end
        P_ECS: begin
          if (byte_i == MK_PFX) st_n = P_ECSFF;
          else ewe_n = 1'b1;
        end
        P_ECSFF: begin
          if (byte_i == 8'h00) begin
            ewe_n = 1'b1; val_n = MK_PFX; st_n = P_ECS;
          end else if (byte_i == MK_EOI) finish = 1'b1;
          else if (byte_i != MK_PFX) fail = 1'b1;
        end
        default: fail = 1'b1;
      endcase
    end
    if (fail) begin
      st_n = P_IDLE; errf_n = 1'b1;
      qwe_n = 1'b0; hwe_n = 1'b0; ewe_n = 1'b0;
    end else if (finish) begin
      st_n = P_IDLE; done_n = 1'b1;
    end
  end

  assign end_o = fail | finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_IDLE;  kind <= K_APP; rem <= '0;  lenh <= '0;
      cnt <= '0;     sum <= '0;     qid <= '0;  hid <= '0;
      hcls <= 1'b0;  w_q <= '0;     h_q <= '0;  errf <= 1'b0;
      qt_we_o <= 1'b0; ht_we_o <= 1'b0; ecs_vld_o <= 1'b0; done_o <= 1'b0;
      idx_o <= '0;   val_o <= '0;
    end else begin
      st <= st_n;    kind <= kind_n; rem <= rem_n; lenh <= lenh_n;
      cnt <= cnt_n;  sum <= sum_n;   qid <= qid_n; hid <= hid_n;
      hcls <= hcls_n; w_q <= w_n;    h_q <= h_n;   errf <= errf_n;
      qt_we_o <= qwe_n; ht_we_o <= hwe_n; ecs_vld_o <= ewe_n; done_o <= done_n;
      if (qwe_n || hwe_n || ewe_n) begin
        idx_o <= idx_n;
        val_o <= val_n;
      end
    end
  end

  assign idle_o   = (st == P_IDLE);
  assign err_o    = errf;
  assign qt_id_o  = qid;
  assign ht_cls_o = hcls;
  assign ht_id_o  = hid;
  assign w_o      = w_q;
  assign h_o      = h_q;
endmodule

// File: rtl/jpg_hdr_walker.sv
module jpg_hdr_walker #(
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int LW = 16,
  parameter int XW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          err_o,
  input  logic [DW-1:0] in_word_i,
  input  logic          in_vld_i,
  output logic          in_rd_o,
  output logic          qt_we_o,
  output logic [1:0]    qt_id_o,
  output logic [5:0]    qt_idx_o,
  output logic [BW-1:0] qt_val_o,
  output logic          ht_we_o,
  output logic          ht_class_o,
  output logic [1:0]    ht_id_o,
  output logic [XW-1:0] ht_idx_o,
  output logic [BW-1:0] ht_val_o,
  output logic [LW-1:0] img_w_o,
  output logic [LW-1:0] img_h_o,
  output logic          ecs_vld_o,
  output logic [BW-1:0] ecs_byte_o
);
  logic          rs_a, rs_b;
  logic          bvld, stop;
  logic [BW-1:0] bval, oval;
  logic [XW-1:0] oidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  jhw_unpack #(.DW(DW), .BW(BW)) u_unpack (
    .clk(clk), .rst_n(rs_b), .active_i(~idle_o), .stop_i(stop),
    .word_i(in_word_i), .vld_i(in_vld_i), .rd_o(in_rd_o),
    .byte_vld_o(bvld), .byte_o(bval)
  );

  jhw_parse #(.BW(BW), .LW(LW), .XW(XW)) u_parse (
    .clk(clk), .rst_n(rs_b), .start_i(start_i), .bvld_i(bvld), .byte_i(bval),
    .idle_o(idle_o), .end_o(stop), .done_o(done_o), .err_o(err_o),
    .qt_we_o(qt_we_o), .qt_id_o(qt_id_o), .ht_we_o(ht_we_o),
    .ht_cls_o(ht_class_o), .ht_id_o(ht_id_o), .idx_o(oidx), .val_o(oval),
    .ecs_vld_o(ecs_vld_o), .w_o(img_w_o), .h_o(img_h_o)
  );

  assign qt_idx_o   = oidx[5:0];
  assign ht_idx_o   = oidx;
  assign qt_val_o   = oval;
  assign ht_val_o   = oval;
  assign ecs_byte_o = oval;
endmodule

// File: rtl/jhw_checker.sv
module jhw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        idle_o,
  input logic        in_rd_o,
  input logic        done_o,
  input logic        err_o,
  input logic        qt_we_o,
  input logic        ht_we_o,
  input logic        ecs_vld_o,
  input logic [15:0] img_w_o,
  input logic [15:0] img_h_o
);
  assert_rd_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_o |-> !idle_o);
  assert_qt_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qt_we_o |-> !idle_o);
  assert_ht_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ht_we_o |-> !idle_o);
  assert_dims_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && $past(idle_o)) |-> ($stable(img_w_o) && $stable(img_h_o)));
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> idle_o);
  assert_one_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({qt_we_o, ht_we_o, ecs_vld_o}));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> idle_o);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind jpg_hdr_walker jhw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .idle_o(idle_o), .in_rd_o(in_rd_o),
  .done_o(done_o), .err_o(err_o), .qt_we_o(qt_we_o), .ht_we_o(ht_we_o),
  .ecs_vld_o(ecs_vld_o), .img_w_o(img_w_o), .img_h_o(img_h_o)
);

// File: tb/sim_jpg_hdr_walker.sv
`timescale 1ns/1ps
module sim_jpg_hdr_walker;
  logic clk = 1'b0;
  logic rst_n, start_i, in_vld_i;
  logic [31:0] in_word_i;
  logic idle_o, done_o, err_o, in_rd_o, qt_we_o, ht_we_o, ht_class_o, ecs_vld_o;
  logic [1:0] qt_id_o, ht_id_o;
  logic [5:0] qt_idx_o;
  logic [8:0] ht_idx_o;
  logic [7:0] qt_val_o, ht_val_o, ecs_byte_o;
  logic [15:0] img_w_o, img_h_o;

  always #2 clk = ~clk;

  jpg_hdr_walker u0 (.*);

  int ncmp = 0, nbad = 0, rdcnt = 0, donecnt = 0;
  bit finished = 0;
  logic [7:0]  bs[$];
  logic [15:0] qlog[$];
  logic [19:0] hlog[$];
  logic [7:0]  elog[$];

  always @(negedge clk) begin
    if (qt_we_o)   qlog.push_back({qt_id_o, qt_idx_o, qt_val_o});
    if (ht_we_o)   hlog.push_back({ht_class_o, ht_id_o, ht_idx_o, ht_val_o});
    if (ecs_vld_o) elog.push_back(ecs_byte_o);
    if (done_o)    donecnt++;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++; ncmp++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  task automatic add(logic [7:0] b); bs.push_back(b); endtask

  task automatic clear_logs();
    qlog.delete(); hlog.delete(); elog.delete(); rdcnt = 0; donecnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic feed();
    int nw = (bs.size() + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w = 32'hAAAA_AAAA;
      bit took = 0;
      for (int k = 0; k < 4; k++)
        if (4*i + k < bs.size()) w[8*k +: 8] = bs[4*i + k];
      if (idle_o) break;
      in_word_i = w; in_vld_i = 1'b1;
      while (!took && !idle_o) begin
        #1;
        if (in_rd_o) begin took = 1; rdcnt++; @(posedge clk); @(negedge clk); end
        else @(negedge clk);
      end
    end
    in_vld_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && !idle_o; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run();
    clear_logs(); pulse_start(); feed(); wait_idle();
  endtask

  task automatic add_sof(logic [7:0] cbsamp);
    add(8'hFF); add(8'hC0); add(8'h00); add(8'h11); add(8'h08);
    add(8'h01); add(8'h23); add(8'h04); add(8'h56); add(8'h03);
    add(8'h01); add(8'h22); add(8'h00);
    add(8'h02); add(cbsamp); add(8'h01);
    add(8'h03); add(8'h11); add(8'h01);
  endtask

  task automatic add_sos();
    add(8'hFF); add(8'hDA); add(8'h00); add(8'h0C);
    for (int i = 0; i < 10; i++) add(8'h3F);
  endtask

  task automatic t_reset();
    chk("R1", "idle after reset", idle_o, 1);
    chk("R1", "err after reset", err_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R6", "width after reset", img_w_o, 0);
    @(negedge clk); in_word_i = 32'hD8FF_D8FF; in_vld_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1; chk("R1", "no read while idle", in_rd_o, 0); @(negedge clk);
    end
    in_vld_i = 1'b0;
  endtask

  task automatic t_full();
    logic [19:0] hexp[$];
    logic [7:0]  eexp[$];
    int nwords;
    bs.delete();
    add(8'hFF); add(8'hD8);
    add(8'hFF); add(8'hE1); add(8'h00); add(8'h06);
    add(8'hDB); add(8'hFF); add(8'h12); add(8'h34);
    add(8'hFF); add(8'hDB); add(8'h00); add(8'h84);
    add(8'h00); for (int k = 0; k < 64; k++) add(8'(k + 1));
    add(8'h01); for (int k = 0; k < 64; k++) add(8'(200 - k));
    add(8'hFF); add(8'hC4); add(8'h00); add(8'h28);
    add(8'h00);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] c = (k == 1) ? 8'd2 : (k == 2) ? 8'd1 : 8'd0;
      add(c); hexp.push_back({1'b0, 2'd0, 9'(k), c});
    end
    for (int k = 0; k < 3; k++) begin
      add(8'(5 + k)); hexp.push_back({1'b0, 2'd0, 9'(16 + k), 8'(5 + k)});
    end
    add(8'h11);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] c = (k == 0) ? 8'd1 : 8'd0;
      add(c); hexp.push_back({1'b1, 2'd1, 9'(k), c});
    end
    add(8'h33); hexp.push_back({1'b1, 2'd1, 9'd16, 8'h33});
    add_sof(8'h11);
    add_sos();
    add(8'h12); add(8'h34); add(8'hFF); add(8'h00); add(8'h56);
    add(8'hFF); add(8'hFF); add(8'h00); add(8'h78);
    eexp = '{8'h12, 8'h34, 8'hFF, 8'h56, 8'hFF, 8'h78};
    while ((bs.size() + 2) % 4 != 0) add(8'hFF);
    add(8'hFF); add(8'hD9);
    nwords = bs.size() / 4;
    run();
    chk("R4", "qt write count", qlog.size(), 128);
    if (qlog.size() == 128)
      for (int k = 0; k < 64; k++) begin
        chk("R4", "qt table0 entry", qlog[k], {2'd0, 6'(k), 8'(k + 1)});
        chk("R4", "qt table1 entry", qlog[64 + k], {2'd1, 6'(k), 8'(200 - k)});
      end
    chk("R8", "app body not parsed, no error", err_o, 0);
    chk("R5", "ht write count", hlog.size(), hexp.size());
    if (hlog.size() == hexp.size())
      foreach (hexp[i]) chk("R5", "ht entry", hlog[i], hexp[i]);
    chk("R6", "height", img_h_o, 16'h0123);
    chk("R6", "width", img_w_o, 16'h0456);
    chk("R10", "entropy byte count", elog.size(), eexp.size());
    if (elog.size() == eexp.size())
      foreach (eexp[i]) chk("R2", "entropy byte order", elog[i], eexp[i]);
    chk("R11", "done pulses", donecnt, 1);
    chk("R11", "idle at end", idle_o, 1);
    chk("R2", "one read per word", rdcnt, nwords);
    @(negedge clk); in_word_i = 32'hDEAD_BEEF; in_vld_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1; chk("R11", "no read after end", in_rd_o, 0); @(negedge clk);
    end
    in_vld_i = 1'b0;
    chk("R6", "width held while idle", img_w_o, 16'h0456);
  endtask

  task automatic t_err(string req, string what);
    run();
    chk(req, what, err_o, 1);
    chk(req, "idle after error", idle_o, 1);
    chk(req, "no done on error", donecnt, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; in_vld_i = 1'b0; in_word_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full();
    bs.delete(); add(8'hFF); add(8'hD8); add(8'hFF); add(8'hDD); add(8'h00); add(8'h04);
    t_err("R9", "restart interval marker");
    bs.delete(); add(8'hFF); add(8'hD8); add_sos(); add(8'h11); add(8'hFF); add(8'hD3);
    t_err("R9", "restart code in entropy data");
    chk("R10", "entropy byte before restart code", elog.size(), 1);
    bs.delete(); add(8'hFF); add(8'hD8); add_sof(8'h21);
    t_err("R7", "bad chroma sampling");
    chk("R12", "error still set while idle", err_o, 1);
    bs.delete(); add(8'hFF); add(8'hD8); add(8'hFF); add(8'hD9);
    run();
    chk("R12", "start clears error", err_o, 0);
    chk("R11", "bare image done", donecnt, 1);
    chk("R6", "start clears width", img_w_o, 0);
    bs.delete(); add(8'h00); add(8'hD8);
    t_err("R3", "missing image start");
    bs.delete(); add(8'hFF); add(8'hD8); add(8'hFF); add(8'hDB); add(8'h00); add(8'h43);
    add(8'h10);
    t_err("R4", "16-bit precision table");
    chk("R4", "no qt writes", qlog.size(), 0);
    bs.delete(); add(8'hFF); add(8'hD8); add(8'hFF); add(8'hFE); add(8'h00); add(8'h04);
    t_err("R12", "unsupported marker");
    finish_run();
  end
endmodule